// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block produces one debug trigger pulse when a programmed series of comparator matches has occurred. Three match pulses come from comparators outside the block, on channels 0, 1 and 2. A 4-bit control code for each sequencer state selects which matches move the sequencer between State1, State2, State3 and a Final state. When Final is reached, the block emits a one-cycle trigger and disarms itself.

Software starts a session by pulsing the arm strobe. The arm strobe also wipes three sticky per-channel match flags. Each flag records whether its channel matched during the session, and it keeps that value after the session ends so software can inspect it afterwards. The flags appear on an 8-bit read port when a 2-bit window select picks the flag window.

State3 interprets its code through a fixed table of per-channel targets. When several matches arrive in the same cycle, a match that leads to Final wins; otherwise the lowest channel number wins. State1 and State2 use a simpler single-channel code of the same width.

Top module: `dbg_seq_trig`

## Requirements
- R1: After reset `seq_state` is 00 (disarmed), `trig_out` is 0 and all three flags are clear. State encoding: 00 disarmed, 01 State1, 10 State2, 11 State3.
- R2: A cycle with `arm_wr` high sets the state to State1 on the next edge and clears all flags. Match inputs in that same cycle are ignored. This applies whether or not the sequencer was already armed.
- R3: In State3, `s3_code` maps each channel to a target, and every other channel has no target:
  - 0001: ch1 to Final, ch2 to State2.
  - 0010: ch0 to Final, ch1 to State1.
  - 0011: ch1 to Final, ch2 to State1.
  - 0100: ch1 to State2.
  - 0101: ch1 to Final.
  - 0110: ch0 to Final, ch2 to State2.
  - 0111: ch0 to Final.
  - 1010: ch0 to Final, ch1 and ch2 to State1.
  - 1101: ch0 to State1, ch1 and ch2 to Final.
  - 1110: ch0 to State2, ch2 to Final.
- R4: In State3, codes 0000, 1000, 1001, 1011, 1100 and 1111 cause no transition. A match on a channel that the code gives no target leaves the state unchanged.
- R5: When several matches with targets arrive in one cycle, a match aimed at Final wins. Otherwise the match on the lowest channel number wins.
- R6: A transition to Final drives `trig_out` high for exactly one cycle and returns the state to 00 on the same edge.
- R7: While the state is 00 and `arm_wr` is low, matches change neither the state nor the flags.
- R8: While armed, a match on channel i sets flag i. Flags set independently of each other. A flag already set stays set, and flags stay set after the session ends.
- R9: Only `arm_wr` clears the flags. No other input clears them.
- R10: With `win_sel` = 11, `rd_data` bit 0 holds the channel-0 flag, bit 1 the channel-1 flag, bit 2 the channel-2 flag, and bits 7..3 read 0. Any other `win_sel` value gives `rd_data` = 0.
- R11: In State1, `s1_code` applies, and in State2, `s2_code` applies. Bits [1:0] of the code select the channel (11 = none). Bits [3:2] select the target for a match on that channel: 00 State1, 01 State2, 10 State3, 11 Final.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_wr | input | 1 | Arm strobe: start a session, clear flags |
| match_in | input | 3 | Comparator match pulses, one per channel |
| s1_code | input | 4 | State1 control code |
| s2_code | input | 4 | State2 control code |
| s3_code | input | 4 | State3 control code |
| win_sel | input | 2 | Read window select |
| rd_data | output | 8 | Read data (flags in window 11) |
| seq_state | output | 2 | Current sequencer state |
| trig_out | output | 1 | One-cycle trigger on reaching Final |

## Verification
Two functions can fall in the same cycle. The arm strobe can arrive together with match pulses, and a transition to Final can coincide with flag capture on several channels. The bench drives random arm strobes over random match patterns, and directed cases put an arm strobe and a match on the same edge. The results are judged by a bench model: arm must win and leave all flags clear, and a Final transition must still record every channel that matched in that cycle.

// File: rtl/dbg_seq_trig.sv
module dbg_seq_trig #(
  parameter int RD_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm_wr,
  input  logic [2:0]      match_in,
  input  logic [3:0]      s1_code,
  input  logic [3:0]      s2_code,
  input  logic [3:0]      s3_code,
  input  logic [1:0]      win_sel,
  output logic [RD_W-1:0] rd_data,
  output logic [1:0]      seq_state,
  output logic            trig_out
);

  localparam logic [1:0] ST_OFF = 2'd0, ST_1 = 2'd1, ST_2 = 2'd2, ST_3 = 2'd3;
  localparam logic [1:0] FLAG_WIN = 2'b11;
  localparam logic [2:0] T_NONE = 3'd0, T_S1 = 3'd1, T_S2 = 3'd2, T_S3 = 3'd3, T_FIN = 3'd4;

  logic [1:0] state;
  logic [2:0] flags;
  logic [2:0] tgt [3];
  logic [2:0] nxt_tgt;

  function automatic logic [8:0] s3_map(input logic [3:0] c);
    case (c)
      4'b0001: s3_map = {T_S2,   T_FIN,  T_NONE};
      4'b0010: s3_map = {T_NONE, T_S1,   T_FIN};
      4'b0011: s3_map = {T_S1,   T_FIN,  T_NONE};
      4'b0100: s3_map = {T_NONE, T_S2,   T_NONE};
      4'b0101: s3_map = {T_NONE, T_FIN,  T_NONE};
      4'b0110: s3_map = {T_S2,   T_NONE, T_FIN};
      4'b0111: s3_map = {T_NONE, T_NONE, T_FIN};
      4'b1010: s3_map = {T_S1,   T_S1,   T_FIN};
      4'b1101: s3_map = {T_FIN,  T_FIN,  T_S1};
      4'b1110: s3_map = {T_FIN,  T_NONE, T_S2};
      default: s3_map = '0;
    endcase
  endfunction

  always_comb begin
    logic [3:0] c12;
    logic [8:0] m3;
    c12 = (state == ST_1) ? s1_code : s2_code;
    m3  = s3_map(s3_code);
    for (int i = 0; i < 3; i++) begin
      if (state == ST_3)
        tgt[i] = m3[3*i +: 3];
      else if ((state == ST_1 || state == ST_2) && c12[1:0] == 2'(i))
        tgt[i] = {1'b0, c12[3:2]} + 3'd1;
      else
        tgt[i] = T_NONE;
    end
    nxt_tgt = T_NONE;
    for (int i = 0; i < 3; i++)
      if (match_in[i] && tgt[i] != T_NONE && nxt_tgt == T_NONE) nxt_tgt = tgt[i];
    for (int i = 0; i < 3; i++)
      if (match_in[i] && tgt[i] == T_FIN) nxt_tgt = T_FIN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      flags    <= '0;
      trig_out <= 1'b0;
    end else begin
      trig_out <= 1'b0;
      if (arm_wr) begin
        state <= ST_1;
        flags <= '0;
      end else if (state != ST_OFF) begin
        flags <= flags | match_in;
        case (nxt_tgt)
          T_S1:  state <= ST_1;
          T_S2:  state <= ST_2;
          T_S3:  state <= ST_3;
          T_FIN: begin
            state    <= ST_OFF;
            trig_out <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign seq_state = state;
  assign rd_data   = (win_sel == FLAG_WIN) ? {{(RD_W-3){1'b0}}, flags} : '0;

  // R6
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out);

  // R6
  trig_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> seq_state == ST_OFF);

  // R2
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_wr |=> (seq_state == ST_1 && rd_data[2:0] == 3'b000 || win_sel != FLAG_WIN));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_OFF && !arm_wr) |=> (seq_state == ST_OFF && $stable(flags)));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_wr |=> ((flags & $past(flags)) == $past(flags)));

  // R10
  always_comb
    if (rst_n && win_sel != FLAG_WIN)
      rd_window_chk: assert (rd_data == '0);

endmodule

// File: tb/dbg_seq_trig_bench.sv
module dbg_seq_trig_bench;
  logic clk = 1'b0, rst_n = 1'b0, arm_wr = 1'b0;
  logic [2:0] match_in = '0;
  logic [3:0] s1_code = '0, s2_code = '0, s3_code = '0;
  logic [1:0] win_sel = '0;
  logic [7:0] rd_data;
  logic [1:0] seq_state;
  logic trig_out;

  int checks = 0, fails = 0;
  int m_state = 0;
  logic [2:0] m_flags = '0;
  logic m_trig = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  dbg_seq_trig u_dbg_seq_trig (.clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .match_in(match_in),
    .s1_code(s1_code), .s2_code(s2_code), .s3_code(s3_code), .win_sel(win_sel),
    .rd_data(rd_data), .seq_state(seq_state), .trig_out(trig_out));

  // destination of one channel in State3: 0 none, 1 S1, 2 S2, 3 S3, 4 Final
  function automatic int s3_dest(input logic [3:0] c, input int ch);
    case (c)
      4'd1:  return (ch == 1) ? 4 : (ch == 2) ? 2 : 0;
      4'd2:  return (ch == 0) ? 4 : (ch == 1) ? 1 : 0;
      4'd3:  return (ch == 1) ? 4 : (ch == 2) ? 1 : 0;
      4'd4:  return (ch == 1) ? 2 : 0;
      4'd5:  return (ch == 1) ? 4 : 0;
      4'd6:  return (ch == 0) ? 4 : (ch == 2) ? 2 : 0;
      4'd7:  return (ch == 0) ? 4 : 0;
      4'd10: return (ch == 0) ? 4 : 1;
      4'd13: return (ch == 0) ? 1 : 4;
      4'd14: return (ch == 0) ? 2 : (ch == 2) ? 4 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int next_dest(input int st, input logic [2:0] m);
    int best = 0;
    logic [3:0] c;
    if (st == 3) begin
      for (int ch = 2; ch >= 0; ch--)
        if (m[ch] && s3_dest(s3_code, ch) != 0) best = s3_dest(s3_code, ch);
      for (int ch = 0; ch < 3; ch++)
        if (m[ch] && s3_dest(s3_code, ch) == 4) best = 4;
    end else if (st == 1 || st == 2) begin
      c = (st == 1) ? s1_code : s2_code;
      if (c[1:0] != 2'b11 && m[c[1:0]]) best = int'(c[3:2]) + 1;
    end
    return best;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic [2:0] m, input string tag);
    int d;
    logic [7:0] exp_rd;
    @(negedge clk);
    arm_wr = a; match_in = m;
    d = next_dest(m_state, m);
    m_trig = 1'b0;
    if (a) begin m_state = 1; m_flags = '0; end
    else if (m_state != 0) begin
      m_flags |= m;
      if (d == 4) begin m_state = 0; m_trig = 1'b1; end
      else if (d != 0) m_state = d;
    end
    @(posedge clk); #2;
    arm_wr = 1'b0; match_in = '0;
    exp_rd = (win_sel == 2'b11) ? {5'b0, m_flags} : 8'h00;
    check(seq_state == 2'(m_state), tag, seq_state, m_state);
    check(trig_out == m_trig, {tag, " R6"}, trig_out, m_trig);
    check(rd_data == exp_rd, {tag, " R10"}, rd_data, exp_rd);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    win_sel = 2'b11;
    #20; @(negedge clk); rst_n = 1'b1;
    #1;
    check(seq_state == 2'd0, "R1 state", seq_state, 0);
    check(trig_out == 1'b0, "R1 trig", trig_out, 0);
    check(rd_data == 8'h00, "R1 flags", rd_data, 0);

    step(0, 3'b111, "R7 idle");
    step(1, 3'b111, "R2 arm with match");
    // State1 -> State3 on ch0
    s1_code = 4'b1000;
    step(0, 3'b010, "R11 wrong ch");
    step(0, 3'b001, "R11 to S3");
    s3_code = 4'b1000;
    step(0, 3'b111, "R4 reserved");
    s3_code = 4'b1010;
    step(0, 3'b110, "R3 1010 to S1");
    step(0, 3'b001, "R11 to S3 again");
    s3_code = 4'b0001;
    step(0, 3'b001, "R4 unnamed ch");
    step(0, 3'b110, "R5 final wins");
    step(0, 3'b111, "R7 after final");
    step(0, 3'b000, "R8 flags kept");
    win_sel = 2'b01;
    step(0, 3'b000, "R10 other window");
    win_sel = 2'b11;
    step(1, 3'b000, "R9 arm clears");
    s1_code = 4'b1000; s3_code = 4'b1110;
    step(0, 3'b001, "R11 to S3");
    step(0, 3'b101, "R5 ch2 final over ch0");
    step(1, 3'b000, "R2 rearm");
    s1_code = 4'b0101;
    step(0, 3'b010, "R11 to S2");
    s2_code = 4'b1000;
    step(0, 3'b001, "R11 S2 to S3");
    s3_code = 4'b1010;
    step(0, 3'b110, "R5 lowest ch");
    s1_code = 4'b1000;
    step(0, 3'b001, "R11 to S3");
    s3_code = 4'b1101;
    step(1, 3'b110, "R2 arm beats final");

    for (int n = 0; n < 4000; n++) begin
      if (n % 23 == 0) begin
        s1_code = 4'($urandom); s2_code = 4'($urandom); s3_code = 4'($urandom);
        win_sel = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
      end
      step(($urandom % 12) == 0, ($urandom % 3 == 0) ? 3'($urandom) : 3'b000, "R3 R5 R8 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule